// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block is a configurable AND-OR array. It evaluates a set of Boolean functions of a small input vector. A set of product terms forms the AND plane. Each product term may include the true form, the inverted form, or neither form of each input. A set of output ORs forms the OR plane. Each output OR may collect any subset of the product terms, so a single term can serve several outputs. Both planes are programmable. The default size is 4 inputs, 6 product terms and 3 outputs.

All configuration bits sit in one shift chain. Software or a boot sequencer loads the chain one bit per clock while the load strobe is high. Each bit drives its connection directly, so a bit takes effect in the same cycle it is shifted into place, and no separate commit step exists. Evaluation from the inputs to the outputs is purely combinational. A reset empties every connection, and an empty array drives all outputs low.

Top module: `sop_array_top`

## Requirements
- R1: While reset is held, and after it is released, all configuration bits are 0 and every output reads 0 for every input value.
- R2: On each rising clock edge with `cfg_load` high, the chain shifts by one and `cfg_data` enters at bit 0. The first bit sent ends up in the highest chain position. For the default size the chain is 66 bits long, with the AND plane in chain bits 65..18 and the OR plane in bits 17..0, so the AND plane is sent first.
- R3: While `cfg_load` is low, the configuration does not change, whatever value `cfg_data` has.
- R4: AND-plane field of term t = AND-plane bits [t*2N +: 2N], where N is the input count. In that field, bit 2i+1 connects the true form of input i and bit 2i connects its inverted form.
- R5: A product term with no literal connected evaluates to 1.
- R6: A product term that connects both forms of the same input evaluates to 0.
- R7: OR-plane field of output o = OR-plane bits [o*P +: P], where P is the term count. Bit t of that field connects product term t to output o.
- R8: An output whose OR-plane field is all zeros reads 0.
- R9: One product term may feed several outputs at the same time.
- R10: Outputs follow input changes combinationally, with no clock edge in between. A newly loaded configuration applies as soon as its last bit is shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration chain |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_load | input | 1 | Shift enable for the configuration chain |
| cfg_data | input | 1 | Serial configuration bit |
| in_vec | input | N_IN | Logic inputs |
| out_vec | output | N_OUT | Sum-of-products results |

## Verification
The bench programs functions whose result depends on chain order and literal polarity. A design with a reversed chain, or with swapped true and inverted bits, therefore produces the wrong truth table. It checks that an empty product term reads 1 and that a contradictory term reads 0. If the term logic were ORed instead of ANDed, or if an unused term were forced low, the result would flip. It checks that an output with no connections reads 0. It sends one term to two outputs, so a design with per-output terms would miss the sharing. It toggles `cfg_data` with the strobe low, which would corrupt a chain that ignores the enable, and it checks that reset applied after programming clears the function.

// File: rtl/sop_pkg.sv
package sop_pkg;
  // Width of the AND plane: two literals per input per product term.
  function automatic int and_plane_bits(input int n_in, input int n_term);
    return 2 * n_in * n_term;
  endfunction

  // Width of the OR plane: one connection per term per output.
  function automatic int or_plane_bits(input int n_term, input int n_out);
    return n_term * n_out;
  endfunction
endpackage

// File: rtl/sop_rst_sync.sv
module sop_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/sop_cfg_chain.sv
module sop_cfg_chain #(
  parameter int WIDTH = 66
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             shift_in,
  output logic [WIDTH-1:0] chain
);
  logic [WIDTH-1:0] chain_q;
  logic [WIDTH-1:0] chain_d;

  // Next state: shift toward the MSB, new bit enters at bit 0.
  always_comb begin
    chain_d = {chain_q[WIDTH-2:0], shift_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else if (shift_en) begin
      chain_q <= chain_d;
    end
  end

  assign chain = chain_q;
endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane #(
  parameter int N_IN   = 4,
  parameter int N_TERM = 6
) (
  input  logic [N_IN-1:0]          in_vec,
  input  logic [2*N_IN*N_TERM-1:0] and_cfg,
  output logic [N_TERM-1:0]        term
);
  localparam int LW = 2 * N_IN;

  logic [LW-1:0] literal;

  // Odd positions hold the true form, even positions hold the inverted form.
  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign literal[2*i+1] = in_vec[i];
    assign literal[2*i]   = ~in_vec[i];
  end

  // An unconnected literal is treated as 1, so an empty term evaluates to 1.
  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [LW-1:0] sel;
    assign sel     = and_cfg[t*LW +: LW];
    assign term[t] = &(~sel | literal);
  end
endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane #(
  parameter int N_TERM = 6,
  parameter int N_OUT  = 3
) (
  input  logic [N_TERM-1:0]       term,
  input  logic [N_TERM*N_OUT-1:0] or_cfg,
  output logic [N_OUT-1:0]        out_vec
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    assign out_vec[o] = |(or_cfg[o*N_TERM +: N_TERM] & term);
  end
endmodule

// File: rtl/sop_array_top.sv
module sop_array_top #(
  parameter int N_IN   = 4,
  parameter int N_TERM = 6,
  parameter int N_OUT  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic             cfg_data,
  input  logic [N_IN-1:0]  in_vec,
  output logic [N_OUT-1:0] out_vec
);
  localparam int AND_BITS = sop_pkg::and_plane_bits(N_IN, N_TERM);
  localparam int OR_BITS  = sop_pkg::or_plane_bits(N_TERM, N_OUT);
  localparam int TOTAL    = AND_BITS + OR_BITS;

  logic             rst_sync_n;
  logic [TOTAL-1:0] cfg_chain;
  logic [N_TERM-1:0] term;

  sop_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sop_cfg_chain #(.WIDTH(TOTAL)) u_chain (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .shift_en (cfg_load),
    .shift_in (cfg_data),
    .chain    (cfg_chain)
  );

  sop_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .in_vec  (in_vec),
    .and_cfg (cfg_chain[TOTAL-1:OR_BITS]),
    .term    (term)
  );

  sop_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
    .term    (term),
    .or_cfg  (cfg_chain[OR_BITS-1:0]),
    .out_vec (out_vec)
  );
endmodule

// File: rtl/sop_array_checker.sv
module sop_array_checker #(
  parameter int N_TERM = 6,
  parameter int N_OUT  = 3,
  parameter int TOTAL  = 66
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_load,
  input logic             cfg_data,
  input logic [TOTAL-1:0] cfg_chain,
  input logic [N_OUT-1:0] out_vec
);
  localparam int OR_BITS = N_TERM * N_OUT;

  assert_reset_clear_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (cfg_chain == '0));

  assert_empty_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_chain == '0) |-> (out_vec == '0));

  assert_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (cfg_chain == {$past(cfg_chain[TOTAL-2:0]), $past(cfg_data)}));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable(cfg_chain));

  for (genvar o = 0; o < N_OUT; o++) begin : g_chk
    assert_empty_or_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_chain[o*N_TERM +: N_TERM] == '0) |-> !out_vec[o]);
  end

  logic unused_ok;
  assign unused_ok = ^cfg_chain[TOTAL-1:OR_BITS];
endmodule

bind sop_array_top sop_array_checker #(
  .N_TERM(N_TERM), .N_OUT(N_OUT), .TOTAL(TOTAL)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cfg_load  (cfg_load),
  .cfg_data  (cfg_data),
  .cfg_chain (cfg_chain),
  .out_vec   (out_vec)
);

// File: tb/sop_array_top_test.sv
module sop_array_top_test;
  localparam int N = 4;
  localparam int P = 6;
  localparam int M = 3;
  localparam int OR_BITS = M * P;
  localparam int TOTAL = 2 * N * P + OR_BITS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_load = 1'b0;
  logic cfg_data = 1'b0;
  logic [N-1:0] in_vec = '0;
  logic [M-1:0] out_vec;

  int checks = 0;
  int errors = 0;
  logic [TOTAL-1:0] cfg;

  always #2 clk = ~clk;

  sop_array_top #(.N_IN(N), .N_TERM(P), .N_OUT(M)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_data(cfg_data),
    .in_vec(in_vec), .out_vec(out_vec)
  );

  // Connect a literal: pol 1 = true form (bit 2i+1), 0 = inverted form (bit 2i).
  task automatic add_lit(input int t, input int i, input int pol);
    cfg[OR_BITS + t*2*N + 2*i + pol] = 1'b1;
  endtask

  task automatic add_or(input int o, input int t);
    cfg[o*P + t] = 1'b1;
  endtask

  function automatic logic [M-1:0] model(input logic [TOTAL-1:0] c, input logic [N-1:0] x);
    logic [M-1:0] r;
    logic tv;
    r = '0;
    for (int t = 0; t < P; t++) begin
      tv = 1'b1;
      for (int i = 0; i < N; i++) begin
        if (c[OR_BITS + t*2*N + 2*i + 1] && !x[i]) tv = 1'b0;
        if (c[OR_BITS + t*2*N + 2*i] && x[i]) tv = 1'b0;
      end
      for (int o = 0; o < M; o++) if (c[o*P + t] && tv) r[o] = 1'b1;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [M-1:0] exp);
    checks++;
    if (out_vec !== exp) begin
      errors++;
      $display("FAIL %s in=%b actual=%b expected=%b", req, in_vec, out_vec, exp);
    end
  endtask

  // Input driven just after a falling edge and sampled 1 ns later, before the rising edge (R10).
  task automatic sweep(input string req, input logic [TOTAL-1:0] c);
    for (int v = 0; v < (1 << N); v++) begin
      @(negedge clk);
      in_vec = v[N-1:0];
      #1;
      check(req, model(c, v[N-1:0]));
    end
  endtask

  task automatic load(input logic [TOTAL-1:0] c);
    for (int k = TOTAL - 1; k >= 0; k--) begin
      @(negedge clk);
      cfg_load = 1'b1;
      cfg_data = c[k];
    end
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic test_reset_R1();
    do_reset();
    sweep("R1 reset state", '0);
  endtask

  // Shared term, polarity and empty-term checks: R2 R4 R5 R7 R9 R10.
  task automatic test_functions();
    cfg = '0;
    add_lit(0, 0, 1); add_lit(0, 1, 0);   // a & ~b
    add_lit(1, 0, 0); add_lit(1, 1, 1);   // ~a & b
    add_lit(2, 2, 1); add_lit(2, 3, 1);   // c & d
    add_or(0, 0); add_or(0, 1);           // out0 = a xor b
    add_or(1, 0); add_or(1, 2);           // out1 shares term 0 (R9)
    add_or(2, 3);                         // out2 = empty term 3 = 1 (R5)
    load(cfg);
    sweep("R2 R4 R7 R9 R10 programmed functions", cfg);
    in_vec = 4'b0001; #0.5;
    check("R9 shared term drives out0 and out1", 3'b111);
    in_vec = 4'b0000; #0.5;
    check("R5 empty term feeds out2", 3'b100);
  endtask

  task automatic test_contra_R6_R8();
    cfg = '0;
    add_lit(0, 0, 1); add_lit(0, 0, 0);   // a & ~a
    add_or(0, 0);
    add_lit(1, 2, 0); add_lit(1, 3, 0);   // ~c & ~d on out2
    add_or(2, 1);
    load(cfg);
    sweep("R6 R8 contradictory term and empty output", cfg);
    in_vec = 4'b0000; #0.5;
    check("R6 a&~a term is 0, R8 out1 unconnected", 3'b100);
  endtask

  task automatic test_hold_R3();
    @(negedge clk);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      cfg_data = k[0];
    end
    sweep("R3 config held with load low", cfg);
  endtask

  task automatic test_reset_after_cfg_R1();
    do_reset();
    sweep("R1 reset after programming", '0);
  endtask

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    test_reset_R1();
    test_functions();
    test_contra_R6_R8();
    test_hold_R3();
    test_reset_after_cfg_R1();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule